// File: doc/BRIEF.md
# Out-of-Order Issue Selector

This block holds a small window of pending instructions and, every cycle, decides which of them leave for a pool of execution units. Each window slot holds a valid flag, a class (generic or math), an identifier and a busy time. The pool has four generic units and two math units. An instruction may only go to a unit of its own class. Lower slot numbers are older. The selector walks the slots from oldest to youngest and gives each free unit to the oldest live instruction that fits it. An older instruction therefore never loses a unit to a younger one of the same class. When every unit of one class is taken, instructions of that class are passed over, and younger instructions of the other class can still go out in the same cycle. The walk stops after a fixed number of live entries, which is the look-ahead depth.

The grant is combinational. It is computed from the registered window, the unit state and the flush mask of the current cycle. A granted slot is cleared at the next clock edge. The unit that takes it stays busy for the number of cycles carried with the instruction. A separate hold input lets a unit declare itself busy. When a branch resolves, the path that was not taken is cancelled by asserting its slots on the flush mask. Those slots are not issued in that cycle and are removed at the edge. New instructions are written into the window one at a time through a slot-addressed write port.

Top module: `oo_issue_sel`

## Requirements
- R1: After synchronous active-high reset, no slot is valid, no unit is busy (with no hold asserted) and no grant is given.
- R2: Units 0 to 3 are generic and units 4 and 5 are math. A slot whose class bit is 1 (math) is only granted to a math unit, and a slot whose class bit is 0 only to a generic unit. With four math entries and all units free, exactly the two oldest are issued.
- R3: Within a class, free units go to the live entries in ascending slot order. The lowest-numbered free unit takes the oldest of those entries.
- R4: When all units of one class are busy or held, entries of that class are skipped, and younger entries of the other class are still issued in the same cycle.
- R5: Take ten live entries in slots 0..9, with math entries in slots 6 and 9 and all units free. Slots 0,1,2,3,6,9 are issued, units 0..3 take slots 0..3, unit 4 takes slot 6 and unit 5 takes slot 9.
- R6: Only the oldest DEPTH live entries (default 12) are candidates. Entries flushed in the current cycle do not count toward the depth.
- R7: A slot set in flush_mask is not issued in that cycle and is invalid after the next clock edge.
- R8: An issued slot is invalid after the next clock edge.
- R9: A unit granted an entry with busy time L reports busy for the L cycles after the grant edge and is free again from the following cycle. L=0 leaves it free.
- R10: A unit whose unit_hold bit is set receives no grant, and unit_busy shows the hold in the same cycle.
- R11: A write loads the addressed slot at the clock edge, valid from the next cycle. A write wins over an issue or flush of the same slot in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one window slot |
| wr_slot | input | 4 | Slot written |
| wr_math | input | 1 | Class of written entry (1 = math) |
| wr_id | input | 8 | Identifier of written entry |
| wr_lat | input | 4 | Busy time the unit takes for this entry |
| flush_mask | input | 16 | Slots cancelled this cycle |
| unit_hold | input | 6 | Units reporting busy from outside |
| win_valid | output | 16 | Live slots of the window |
| issue_mask | output | 16 | Slots issued this cycle |
| grant_vld | output | 6 | Unit receives an entry this cycle |
| grant_slot | output | 6x4 | Slot sent to each unit |
| grant_id | output | 6x8 | Identifier sent to each unit |
| unit_busy | output | 6 | Unit busy (hold or running) |

## Verification
A stale valid bit shows up in the same cycle as a second grant of an issued identifier, and the next window read shows a slot that should be gone. A wrong class bit or a corrupt walk order shows immediately as a wrong issue_mask or a wrong slot on a unit. A miscounted busy timer shows as unit_busy still high, or a unit going idle, one or more cycles after the expected edge. A depth counter that includes flushed entries drops a young entry that should have been issued in that same cycle.

// File: rtl/oo_issue_pkg.sv
package oo_issue_pkg;

  // Unit numbering: generic units first, math units after them.
  function automatic logic unit_is_math(input int unsigned u, input int unsigned n_gen);
    return (u >= n_gen);
  endfunction

  function automatic logic class_fits(input logic ent_math, input int unsigned u,
                                      input int unsigned n_gen);
    return ent_math == unit_is_math(u, n_gen);
  endfunction

  // Look-ahead bound: an entry is a candidate while fewer than depth live
  // entries stand ahead of it.
  function automatic logic within_depth(input int unsigned seen, input int unsigned depth);
    return seen < depth;
  endfunction

endpackage

// File: rtl/oo_issue_window.sv
module oo_issue_window #(
  parameter int WIN   = 16,
  parameter int ID_W  = 8,
  parameter int LAT_W = 4,
  localparam int SW   = $clog2(WIN)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [SW-1:0]              wr_slot,
  input  logic                       wr_math,
  input  logic [ID_W-1:0]            wr_id,
  input  logic [LAT_W-1:0]           wr_lat,
  input  logic [WIN-1:0]             clr_mask,
  output logic [WIN-1:0]             valid,
  output logic [WIN-1:0]             math,
  output logic [WIN-1:0][ID_W-1:0]   id,
  output logic [WIN-1:0][LAT_W-1:0]  lat
);

  for (genvar s = 0; s < WIN; s++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_slot == SW'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        valid[s] <= 1'b0;
        math[s]  <= 1'b0;
        id[s]    <= '0;
        lat[s]   <= '0;
      end else if (hit) begin
        valid[s] <= 1'b1;
        math[s]  <= wr_math;
        id[s]    <= wr_id;
        lat[s]   <= wr_lat;
      end else if (clr_mask[s]) begin
        valid[s] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/oo_issue_pick.sv
module oo_issue_pick
  import oo_issue_pkg::*;
#(
  parameter int WIN   = 16,
  parameter int DEPTH = 12,
  parameter int NG    = 4,
  parameter int NM    = 2,
  parameter int ID_W  = 8,
  parameter int LAT_W = 4,
  localparam int NU   = NG + NM,
  localparam int SW   = $clog2(WIN)
) (
  input  logic [WIN-1:0]             valid,
  input  logic [WIN-1:0]             math,
  input  logic [WIN-1:0][ID_W-1:0]   id,
  input  logic [WIN-1:0][LAT_W-1:0]  lat,
  input  logic [WIN-1:0]             flush,
  input  logic [NU-1:0]              unit_free,
  output logic [WIN-1:0]             issue,
  output logic [NU-1:0]              g_vld,
  output logic [NU-1:0][SW-1:0]      g_slot,
  output logic [NU-1:0][ID_W-1:0]    g_id,
  output logic [NU-1:0][LAT_W-1:0]   g_lat
);

  logic [NU-1:0] avail;
  logic          took;
  int unsigned   seen;

  always_comb begin
    avail  = unit_free;
    seen   = 0;
    took   = 1'b0;
    issue  = '0;
    g_vld  = '0;
    g_slot = '0;
    g_id   = '0;
    g_lat  = '0;
    for (int s = 0; s < WIN; s++) begin
      if (valid[s] && !flush[s] && within_depth(seen, DEPTH)) begin
        seen = seen + 1;
        took = 1'b0;
        for (int u = 0; u < NU; u++) begin
          if (!took && avail[u] && class_fits(math[s], u, NG)) begin
            took      = 1'b1;
            avail[u]  = 1'b0;
            issue[s]  = 1'b1;
            g_vld[u]  = 1'b1;
            g_slot[u] = SW'(s);
            g_id[u]   = id[s];
            g_lat[u]  = lat[s];
          end
        end
      end
    end
  end

endmodule

// File: rtl/oo_issue_timers.sv
module oo_issue_timers #(
  parameter int NU    = 6,
  parameter int LAT_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NU-1:0]            g_vld,
  input  logic [NU-1:0][LAT_W-1:0] g_lat,
  output logic [NU-1:0]            busy
);

  for (genvar u = 0; u < NU; u++) begin : g_unit
    logic [LAT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (g_vld[u])    cnt <= g_lat[u];
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
    assign busy[u] = (cnt != '0);
  end

endmodule

// File: rtl/oo_issue_sel.sv
module oo_issue_sel #(
  parameter int WIN   = 16,
  parameter int DEPTH = 12,
  parameter int NG    = 4,
  parameter int NM    = 2,
  parameter int ID_W  = 8,
  parameter int LAT_W = 4,
  localparam int NU   = NG + NM,
  localparam int SW   = $clog2(WIN)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [SW-1:0]            wr_slot,
  input  logic                     wr_math,
  input  logic [ID_W-1:0]          wr_id,
  input  logic [LAT_W-1:0]         wr_lat,
  input  logic [WIN-1:0]           flush_mask,
  input  logic [NU-1:0]            unit_hold,
  output logic [WIN-1:0]           win_valid,
  output logic [WIN-1:0]           issue_mask,
  output logic [NU-1:0]            grant_vld,
  output logic [NU-1:0][SW-1:0]    grant_slot,
  output logic [NU-1:0][ID_W-1:0]  grant_id,
  output logic [NU-1:0]            unit_busy
);

  // Named internal events, visible to the bound checker.
  logic [WIN-1:0]             win_math;
  logic [WIN-1:0][ID_W-1:0]   win_id;
  logic [WIN-1:0][LAT_W-1:0]  win_lat;
  logic [NU-1:0][LAT_W-1:0]   grant_lat;
  logic [NU-1:0]              timer_busy;
  logic [NU-1:0]              unit_free;
  logic [WIN-1:0]             clr_mask;

  assign unit_free = ~(unit_hold | timer_busy);
  assign unit_busy = unit_hold | timer_busy;
  assign clr_mask  = issue_mask | flush_mask;

  oo_issue_window #(.WIN(WIN), .ID_W(ID_W), .LAT_W(LAT_W)) u_win (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_math(wr_math),
    .wr_id(wr_id), .wr_lat(wr_lat), .clr_mask(clr_mask),
    .valid(win_valid), .math(win_math), .id(win_id), .lat(win_lat)
  );

  oo_issue_pick #(.WIN(WIN), .DEPTH(DEPTH), .NG(NG), .NM(NM),
                  .ID_W(ID_W), .LAT_W(LAT_W)) u_pick (
    .valid(win_valid), .math(win_math), .id(win_id), .lat(win_lat),
    .flush(flush_mask), .unit_free(unit_free),
    .issue(issue_mask), .g_vld(grant_vld), .g_slot(grant_slot),
    .g_id(grant_id), .g_lat(grant_lat)
  );

  oo_issue_timers #(.NU(NU), .LAT_W(LAT_W)) u_tmr (
    .clk(clk), .rst(rst), .g_vld(grant_vld), .g_lat(grant_lat),
    .busy(timer_busy)
  );

endmodule

// File: rtl/oo_issue_sel_chk.sv
module oo_issue_sel_chk #(
  parameter int WIN   = 16,
  parameter int NG    = 4,
  parameter int NM    = 2,
  parameter int LAT_W = 4,
  localparam int NU   = NG + NM,
  localparam int SW   = $clog2(WIN)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_en,
  input logic [SW-1:0]           wr_slot,
  input logic [WIN-1:0]          flush_mask,
  input logic [NU-1:0]           unit_hold,
  input logic [WIN-1:0]          win_valid,
  input logic [WIN-1:0]          win_math,
  input logic [WIN-1:0]          issue_mask,
  input logic [NU-1:0]           grant_vld,
  input logic [NU-1:0][SW-1:0]   grant_slot,
  input logic [NU-1:0][LAT_W-1:0] grant_lat,
  input logic [NU-1:0]           unit_busy
);

  // R3: one unit per issued slot.
  a_r3_grant_count: assert property (@(posedge clk) disable iff (rst)
    $countones(issue_mask) == $countones(grant_vld));

  // R7: flushed slots never issue.
  a_r7_flush_no_issue: assert property (@(posedge clk) disable iff (rst)
    (issue_mask & flush_mask) == '0);

  // R10: held units receive nothing.
  a_r10_hold_blocks: assert property (@(posedge clk) disable iff (rst)
    (grant_vld & unit_hold) == '0);

  for (genvar u = 0; u < NU; u++) begin : g_u
    // R2: class of the slot matches the unit class.
    a_r2_class_match: assert property (@(posedge clk) disable iff (rst)
      grant_vld[u] |-> (win_valid[grant_slot[u]] &&
                        (win_math[grant_slot[u]] == 1'(u >= NG))));
    // R9: a nonzero busy time keeps the unit busy and ungranted next cycle.
    a_r9_busy_after: assert property (@(posedge clk) disable iff (rst)
      (grant_vld[u] && grant_lat[u] != '0) |=> (unit_busy[u] && !grant_vld[u]));
  end

  for (genvar s = 0; s < WIN; s++) begin : g_s
    // R8: an issued slot is gone next cycle unless rewritten.
    a_r8_clear_issued: assert property (@(posedge clk) disable iff (rst)
      (issue_mask[s] && !(wr_en && wr_slot == SW'(s))) |=> !win_valid[s]);
  end

endmodule

bind oo_issue_sel oo_issue_sel_chk #(.WIN(WIN), .NG(NG), .NM(NM), .LAT_W(LAT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot),
  .flush_mask(flush_mask), .unit_hold(unit_hold),
  .win_valid(win_valid), .win_math(win_math), .issue_mask(issue_mask),
  .grant_vld(grant_vld), .grant_slot(grant_slot), .grant_lat(grant_lat),
  .unit_busy(unit_busy)
);

// File: tb/oo_issue_sel_tb.sv
module oo_issue_sel_tb;

  logic             clk = 1'b0;
  logic             rst;
  logic             wr_en;
  logic [3:0]       wr_slot;
  logic             wr_math;
  logic [7:0]       wr_id;
  logic [3:0]       wr_lat;
  logic [15:0]      flush_mask;
  logic [5:0]       unit_hold;
  logic [15:0]      win_valid;
  logic [15:0]      issue_mask;
  logic [5:0]       grant_vld;
  logic [5:0][3:0]  grant_slot;
  logic [5:0][7:0]  grant_id;
  logic [5:0]       unit_busy;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  oo_issue_sel u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot), .wr_math(wr_math),
    .wr_id(wr_id), .wr_lat(wr_lat), .flush_mask(flush_mask), .unit_hold(unit_hold),
    .win_valid(win_valid), .issue_mask(issue_mask), .grant_vld(grant_vld),
    .grant_slot(grant_slot), .grant_id(grant_id), .unit_busy(unit_busy)
  );

  // {valid, math, hold, flush, expected issue}
  localparam int NV = 10;
  localparam logic [69:0] VEC [NV] = '{
    {16'h03FF, 16'h0240, 6'h00, 16'h0000, 16'h024F},  // R5 example
    {16'h003F, 16'h0010, 6'h0F, 16'h0000, 16'h0010},  // R4 bypass
    {16'h0AA4, 16'h0000, 6'h02, 16'h0000, 16'h00A4},  // R3 order
    {16'h000F, 16'h000F, 6'h00, 16'h0005, 16'h000A},  // R7 flush
    {16'h000F, 16'h000F, 6'h00, 16'h0000, 16'h0003},  // R2 class
    {16'h3FFF, 16'h2000, 6'h00, 16'h0000, 16'h000F},  // R6 beyond depth
    {16'h0FFF, 16'h0800, 6'h00, 16'h0000, 16'h080F},  // R6 at depth
    {16'h00FF, 16'h0080, 6'h35, 16'h0000, 16'h0003},  // R10 holds
    {16'h0000, 16'h0000, 6'h00, 16'h0000, 16'h0000},  // R1 empty
    {16'h3FFF, 16'h2000, 6'h00, 16'h0003, 16'h203C}   // R6 flushed not counted
  };

  function automatic string vtag(input int i);
    case (i)
      0: return "R5"; 1: return "R4"; 2: return "R3"; 3: return "R7";
      4: return "R2"; 5: return "R6"; 6: return "R6"; 7: return "R10";
      8: return "R1"; default: return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input int s, input logic m, input logic [7:0] id, input logic [3:0] l);
    wr_en = 1'b1; wr_slot = 4'(s); wr_math = m; wr_id = id; wr_lat = l;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clean();
    unit_hold = 6'h3F; flush_mask = 16'hFFFF;
    @(negedge clk);
    flush_mask = '0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_slot = '0; wr_math = 1'b0; wr_id = '0; wr_lat = '0;
    flush_mask = '0; unit_hold = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check(win_valid == '0, "R1", 32'(win_valid), 0);
    check(unit_busy == '0, "R1", 32'(unit_busy), 0);
    check(grant_vld == '0 && issue_mask == '0, "R1", 32'(grant_vld), 0);
    @(negedge clk);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      logic [15:0] vv, vm, vf, ve;
      logic [5:0]  vh;
      {vv, vm, vh, vf, ve} = VEC[v];
      unit_hold = 6'h3F;
      for (int s = 0; s < 16; s++)
        if (vv[s]) load(s, vm[s], 8'(s), 4'd0);
      unit_hold = vh; flush_mask = vf;
      #1;
      check(issue_mask == ve, vtag(v), 32'(issue_mask), 32'(ve));
      @(negedge clk);
      flush_mask = '0;
      // R8 issued and flushed slots gone after the edge
      check(win_valid == (vv & ~ve & ~vf), "R8", 32'(win_valid), 32'(vv & ~ve & ~vf));
      clean();
    end

    // R5 unit mapping
    unit_hold = 6'h3F;
    for (int s = 0; s < 10; s++) load(s, (s == 6 || s == 9), 8'(8'h40 + s), 4'd0);
    unit_hold = '0;
    #1;
    check(grant_vld == 6'h3F, "R5", 32'(grant_vld), 32'h3F);
    for (int u = 0; u < 4; u++)
      check(grant_slot[u] == 4'(u) && grant_id[u] == 8'(8'h40 + u), "R5",
            32'({grant_slot[u], grant_id[u]}), 32'({4'(u), 8'(8'h40 + u)}));
    check(grant_slot[4] == 4'd6 && grant_id[4] == 8'h46, "R5", 32'(grant_slot[4]), 6);
    check(grant_slot[5] == 4'd9 && grant_id[5] == 8'h49, "R5", 32'(grant_slot[5]), 9);
    @(negedge clk);
    clean();

    // R10 hold visible on unit_busy
    unit_hold = 6'h21;
    #1;
    check(unit_busy == 6'h21, "R10", 32'(unit_busy), 32'h21);
    @(negedge clk);

    // R9 busy time
    unit_hold = 6'h3F;
    load(0, 1'b0, 8'h55, 4'd3);
    unit_hold = '0;
    #1;
    check(grant_vld == 6'h01 && grant_id[0] == 8'h55, "R9", 32'(grant_vld), 1);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check(unit_busy[0] == 1'b1, "R9", 32'(unit_busy), 1);
      @(negedge clk);
    end
    check(unit_busy[0] == 1'b0, "R9", 32'(unit_busy), 0);

    // R9 second entry goes to unit 1 while unit 0 is busy
    unit_hold = 6'h3F;
    load(1, 1'b0, 8'h60, 4'd2);
    unit_hold = '0;
    #1;
    check(grant_vld == 6'h01, "R9", 32'(grant_vld), 1);  // unit 0 free again by now
    @(negedge clk);
    unit_hold = 6'h3F;
    load(2, 1'b0, 8'h61, 4'd0);
    unit_hold = '0;
    #1;
    check(grant_vld == 6'h02 && grant_id[1] == 8'h61, "R9", 32'(grant_vld), 2);
    @(negedge clk);
    clean();
    repeat (3) @(negedge clk);

    // R11 write wins over issue of the same slot
    unit_hold = 6'h3F;
    load(4, 1'b0, 8'h11, 4'd0);
    unit_hold = '0;
    wr_en = 1'b1; wr_slot = 4'd4; wr_math = 1'b0; wr_id = 8'h22; wr_lat = '0;
    #1;
    check(issue_mask == 16'h0010 && grant_id[0] == 8'h11, "R11", 32'(grant_id[0]), 32'h11);
    @(negedge clk);
    wr_en = 1'b0;
    check(win_valid == 16'h0010, "R11", 32'(win_valid), 32'h10);
    #1;
    check(grant_vld == 6'h01 && grant_id[0] == 8'h22, "R11", 32'(grant_id[0]), 32'h22);
    @(negedge clk);
    check(win_valid == '0, "R8", 32'(win_valid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule